// File: doc/BRIEF.md
# Packet Receive FIFO with Overflow Handling

This block buffers frames arriving as a byte stream from a network receiver and hands them to a host through a 16-bit register port. Each stored byte carries a tag marking the end of its frame. Only bytes of fully received frames are visible to the host. The block raises a transfer request once enough committed data is buffered. A host read returns one byte, or two bytes of the same frame, and the response flags the byte that closes a frame.

The receive stream uses valid/ready, but the block never applies back-pressure: `in_ready` is tied high, and a byte is consumed in every cycle where `in_valid` is high. The block can only drop data, never stall it. When the storage fills while a frame is being written, the partial frame is removed by rolling the write pointer back to that frame's start. Frames completed earlier stay readable. All later frames are refused until the host reads the status register, which reports the overflow, empties the storage and reopens reception. Frames lost this way that passed the address filter (`in_accept` high on the first byte) are counted in a saturating counter.

Host register selection on `host_addr`: 0 is receive data, 1 is status, 2 is missed-frame count. Every response appears one cycle after the access, on `host_dtv`, `host_rdata` and `host_eof`.

Top module: `rx_pkt_fifo`

## Requirements
- R1: Stored bytes are read in arrival order. A word read (`host_be`=11) returns two bytes of one frame, the earlier byte in bits 7:0 and the later byte in bits 15:8 when `cfg_swap`=0, and the reverse order when `cfg_swap`=1. If only one byte remains in the frame, it is placed in the earlier byte's lane and the other lane is zero.
- R2: `rd_req` is high while the count of bytes in completed frames is at least THR_HI (default 64), or at least THR_LO (default 12) when `cfg_low_lat`=1. Bytes of a frame still being received are not counted.
- R3: A data read made while `rd_req` has not been high since the storage was last empty returns `host_dtv`=0. Once `rd_req` has been high, reads continue to succeed after it drops, until no committed byte remains. A read of empty storage returns `host_dtv`=0.
- R4: A write access (`host_wr`=1) to any register changes nothing and returns `host_dtv`=0.
- R5: `host_eof` is 1 on the response that carries the last byte of a frame, and 0 on other data responses.
- R6: A byte read with `host_be`=01 returns the byte in bits 7:0, and with `host_be`=10 returns it in bits 15:8. The other lane is zero in both cases.
- R7: If a byte of an accepted frame arrives while the storage holds DEPTH bytes, the overflow flag is set, `irq` pulses high for one cycle, and the partial frame is discarded. Previously completed frames remain readable.
- R8: While the overflow flag is set, no frame is stored, whatever the value of `in_accept`. A frame with `in_accept`=0 on its first byte is never stored and never counted.
- R9: Each frame with `in_accept`=1 that is lost to overflow, including the frame that caused it, increments an 8-bit missed-frame counter. The counter saturates at 255, and a read of register 2 returns the count and clears it.
- R10: A read of register 2'd1 returns the overflow flag in bit 0 with `host_eof` equal to that bit. If the flag was set, the read empties the storage, clears the flag and lets new frames be stored again.
- R11: `in_ready` is always 1, and every byte presented with `in_valid`=1 is consumed in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Receive byte valid |
| in_ready | output | 1 | Always 1; no back-pressure |
| in_data | input | 8 | Receive byte |
| in_last | input | 1 | Byte is the last of its frame |
| in_accept | input | 1 | Address filter result, sampled on a frame's first byte |
| cfg_low_lat | input | 1 | Select low request threshold |
| cfg_swap | input | 1 | Byte order of word reads |
| host_sel | input | 1 | Host access strobe |
| host_wr | input | 1 | Access is a write |
| host_addr | input | 2 | Register select: 0 data, 1 status, 2 missed count |
| host_be | input | 2 | Byte lane enables for data reads |
| host_dtv | output | 1 | Access acknowledged with valid data |
| host_rdata | output | 16 | Read data |
| host_eof | output | 1 | Response closes a frame (or reports overflow) |
| rd_req | output | 1 | Transfer request |
| irq | output | 1 | One-cycle pulse on overflow detection |

## Verification
Word reads are swept over frame lengths 4 to 11 under both byte orders. Odd and even lengths separate the two-byte case from the lone-last-byte case, and they show whether `host_eof` lands on the correct response. A three-byte frame followed by a one-byte frame probes the exact threshold edge, and byte reads alternating between the two lanes check lane placement. The overflow pattern fills the storage with one complete frame and part of a second. It then sends an accepted frame, a rejected frame and a long run of one-byte frames. This tells apart the rollback, the frames kept from before the overflow, the refusal of new frames, the counting rules and saturation, the flush, and the reopening of reception.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;

  typedef enum logic [1:0] {
    RX_IDLE    = 2'd0,
    RX_STORE   = 2'd1,
    RX_DISCARD = 2'd2
  } rx_state_e;

  localparam logic [1:0] REG_DATA = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_MISS = 2'd2;

endpackage

// File: rtl/rx_fifo_store.sv
module rx_fifo_store
  import rx_fifo_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  input  logic        in_accept,
  input  logic [1:0]  pop,
  input  logic        flush,
  output logic [AW:0] avail,
  output logic [7:0]  b0,
  output logic        l0,
  output logic [7:0]  b1,
  output logic        l1,
  output logic        ovf,
  output logic        ovf_evt,
  output logic        miss_evt
);

  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW:0] ONE      = (AW+1)'(1);

  logic [8:0]  mem [DEPTH];
  logic [AW:0] wptr, rptr, cptr;
  logic [AW:0] rptr_n1;
  logic        full, store_byte;
  rx_state_e   state, nxt_state;

  assign avail   = cptr - rptr;
  assign full    = (wptr - rptr) == FULL_CNT;
  assign rptr_n1 = rptr + ONE;
  assign {l0, b0} = mem[rptr[AW-1:0]];
  assign {l1, b1} = mem[rptr_n1[AW-1:0]];

  always_comb begin
    store_byte = 1'b0;
    ovf_evt    = 1'b0;
    miss_evt   = 1'b0;
    nxt_state  = state;
    if (in_valid) begin
      unique case (state)
        RX_IDLE: begin
          if (!in_accept) begin
            nxt_state = in_last ? RX_IDLE : RX_DISCARD;
          end else if (ovf) begin
            miss_evt  = 1'b1;
            nxt_state = in_last ? RX_IDLE : RX_DISCARD;
          end else if (full) begin
            ovf_evt   = 1'b1;
            miss_evt  = 1'b1;
            nxt_state = in_last ? RX_IDLE : RX_DISCARD;
          end else begin
            store_byte = 1'b1;
            nxt_state  = in_last ? RX_IDLE : RX_STORE;
          end
        end
        RX_STORE: begin
          if (full) begin
            ovf_evt   = 1'b1;
            miss_evt  = 1'b1;
            nxt_state = in_last ? RX_IDLE : RX_DISCARD;
          end else begin
            store_byte = 1'b1;
            nxt_state  = in_last ? RX_IDLE : RX_STORE;
          end
        end
        default: nxt_state = in_last ? RX_IDLE : RX_DISCARD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (store_byte) mem[wptr[AW-1:0]] <= {in_last, in_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      cptr  <= '0;
      ovf   <= 1'b0;
      state <= RX_IDLE;
    end else begin
      state <= nxt_state;
      if (flush) begin
        wptr <= '0;
        rptr <= '0;
        cptr <= '0;
        ovf  <= 1'b0;
      end else begin
        rptr <= rptr + (AW+1)'(pop);
        if (store_byte) begin
          wptr <= wptr + ONE;
          if (in_last) cptr <= wptr + ONE;
        end
        if (ovf_evt) begin
          wptr <= cptr;
          ovf  <= 1'b1;
        end
      end
    end
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !flush) |=> ovf); // R8
  AST_OVF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !flush) |=> $stable(wptr)); // R8
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && ovf) |=> (avail == '0)); // R10
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ((wptr - rptr) <= FULL_CNT) && (avail <= (wptr - rptr))); // R7

endmodule

// File: rtl/rx_fifo_miss_ctr.sv
module rx_fifo_miss_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] MAXV = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (clr)           cnt <= inc ? W'(1) : '0;
    else if (inc && cnt != MAXV) cnt <= cnt + W'(1);
  end

  AST_MISS_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == MAXV && !clr) |=> (cnt == MAXV)); // R9
  AST_MISS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(cnt)); // R9

endmodule

// File: rtl/rx_fifo_lanes.sv
module rx_fifo_lanes (
  input  logic [1:0]  be,
  input  logic        swap,
  input  logic        two,
  input  logic [7:0]  b0,
  input  logic [7:0]  b1,
  output logic [15:0] word
);

  always_comb begin
    word = 16'h0000;
    unique case (be)
      2'b11: begin
        if (two) word = swap ? {b0, b1} : {b1, b0};
        else     word = swap ? {b0, 8'h00} : {8'h00, b0};
      end
      2'b10:   word = {b0, 8'h00};
      2'b01:   word = {8'h00, b0};
      default: word = 16'h0000;
    endcase
  end

endmodule

// File: rtl/rx_pkt_fifo.sv
module rx_pkt_fifo
  import rx_fifo_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int THR_HI = 64,
  parameter int THR_LO = 12,
  parameter int MISS_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  input  logic        in_accept,
  input  logic        cfg_low_lat,
  input  logic        cfg_swap,
  input  logic        host_sel,
  input  logic        host_wr,
  input  logic [1:0]  host_addr,
  input  logic [1:0]  host_be,
  output logic        host_dtv,
  output logic [15:0] host_rdata,
  output logic        host_eof,
  output logic        rd_req,
  output logic        irq
);

  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] THR_HI_W = (AW+1)'(THR_HI);
  localparam logic [AW:0] THR_LO_W = (AW+1)'(THR_LO);
  localparam logic [AW:0] TWO_W    = (AW+1)'(2);

  logic [AW:0]       avail;
  logic [7:0]        b0, b1;
  logic              l0, l1, ovf, ovf_evt, miss_evt;
  logic [1:0]        pop;
  logic              flush, miss_clr, armed_q;
  logic              rd_acc, data_ok, two, stat_acc, miss_acc;
  logic [15:0]       lane_word;
  logic [MISS_W-1:0] miss_cnt;

  assign in_ready = 1'b1;

  rx_fifo_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_accept(in_accept),
    .pop(pop), .flush(flush), .avail(avail),
    .b0(b0), .l0(l0), .b1(b1), .l1(l1),
    .ovf(ovf), .ovf_evt(ovf_evt), .miss_evt(miss_evt)
  );

  rx_fifo_miss_ctr #(.W(MISS_W)) u_miss (
    .clk(clk), .rst_n(rst_n), .inc(miss_evt), .clr(miss_clr), .cnt(miss_cnt)
  );

  rx_fifo_lanes u_lanes (
    .be(host_be), .swap(cfg_swap), .two(two), .b0(b0), .b1(b1), .word(lane_word)
  );

  assign rd_req   = avail >= (cfg_low_lat ? THR_LO_W : THR_HI_W);
  assign rd_acc   = host_sel && !host_wr;
  assign data_ok  = rd_acc && host_addr == REG_DATA && host_be != 2'b00
                    && (rd_req || armed_q) && avail != '0;
  assign two      = host_be == 2'b11 && avail >= TWO_W && !l0;
  assign pop      = data_ok ? (two ? 2'd2 : 2'd1) : 2'd0;
  assign stat_acc = rd_acc && host_addr == REG_STAT;
  assign miss_acc = rd_acc && host_addr == REG_MISS;
  assign flush    = stat_acc && ovf;
  assign miss_clr = miss_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q    <= 1'b0;
      host_dtv   <= 1'b0;
      host_rdata <= '0;
      host_eof   <= 1'b0;
      irq        <= 1'b0;
    end else begin
      irq <= ovf_evt;
      if (rd_req)            armed_q <= 1'b1;
      else if (avail == '0)  armed_q <= 1'b0;
      host_dtv   <= data_ok || stat_acc || miss_acc;
      host_rdata <= '0;
      host_eof   <= 1'b0;
      if (data_ok) begin
        host_rdata <= lane_word;
        host_eof   <= two ? l1 : l0;
      end else if (stat_acc) begin
        host_rdata <= {15'd0, ovf};
        host_eof   <= ovf;
      end else if (miss_acc) begin
        host_rdata <= 16'(miss_cnt);
      end
    end
  end

  AST_WRITE_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && host_wr) |=> !host_dtv); // R4
  AST_EMPTY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && !host_wr && host_addr == REG_DATA && avail == '0) |=> !host_dtv); // R3
  AST_IRQ_ON_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> irq); // R7
  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready); // R11

endmodule

// File: tb/tb_rx_pkt_fifo.sv
module tb_rx_pkt_fifo;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_last = 1'b0, in_accept = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        cfg_low_lat = 1'b0, cfg_swap = 1'b0;
  logic        host_sel = 1'b0, host_wr = 1'b0;
  logic [1:0]  host_addr = 2'd0, host_be = 2'b11;
  logic        in_ready, host_dtv, host_eof, rd_req, irq;
  logic [15:0] host_rdata;

  int errors = 0, checks = 0, irq_cnt = 0;
  logic        r_dtv, r_eof;
  logic [15:0] r_data;

  always #2 clk = ~clk;

  rx_pkt_fifo #(.DEPTH(32), .THR_HI(16), .THR_LO(4)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .in_accept(in_accept),
    .cfg_low_lat(cfg_low_lat), .cfg_swap(cfg_swap),
    .host_sel(host_sel), .host_wr(host_wr), .host_addr(host_addr), .host_be(host_be),
    .host_dtv(host_dtv), .host_rdata(host_rdata), .host_eof(host_eof),
    .rd_req(rd_req), .irq(irq)
  );

  always @(posedge clk) if (rst_n && irq) irq_cnt = irq_cnt + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [1:0] addr, input logic [1:0] be);
    @(negedge clk);
    host_sel = 1'b1; host_wr = wr; host_addr = addr; host_be = be;
    @(negedge clk);
    host_sel = 1'b0; host_wr = 1'b0;
    r_dtv = host_dtv; r_data = host_rdata; r_eof = host_eof;
  endtask

  task automatic send_frame(input int base, input int len, input logic acc);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'(base + i); in_last = (i == len - 1); in_accept = acc;
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic read_frame(input int base, input int len, input logic swp, input string req);
    int idx = 0;
    while (idx < len) begin
      logic [7:0]  e0, e1;
      logic [15:0] ew;
      int n;
      n  = (len - idx >= 2) ? 2 : 1;
      e0 = 8'(base + idx);
      e1 = 8'(base + idx + 1);
      if (n == 2) ew = swp ? {e0, e1} : {e1, e0};
      else        ew = swp ? {e0, 8'h00} : {8'h00, e0};
      access(1'b0, 2'd0, 2'b11);
      chk(r_dtv == 1'b1, {req, " R3 dtv"}, 32'(r_dtv), 32'd1);
      chk(r_data == ew, {req, " R1 word"}, 32'(r_data), 32'(ew));
      chk(r_eof == (idx + n == len), {req, " R5 eof"}, 32'(r_eof), 32'(idx + n == len));
      idx += n;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(rd_req == 1'b0, "R2 reset", 32'(rd_req), 32'd0);
    chk(host_dtv == 1'b0, "R3 reset", 32'(host_dtv), 32'd0);
    chk(in_ready == 1'b1, "R11 ready", 32'(in_ready), 32'd1);
    access(1'b0, 2'd2, 2'b11);
    chk(r_data == 16'd0, "R9 reset count", 32'(r_data), 32'd0);

    // below threshold, high mode
    send_frame(8'h10, 3, 1'b1);
    chk(rd_req == 1'b0, "R2 below hi", 32'(rd_req), 32'd0);
    access(1'b0, 2'd0, 2'b11);
    chk(r_dtv == 1'b0, "R3 read before request", 32'(r_dtv), 32'd0);
    access(1'b1, 2'd0, 2'b11);
    chk(r_dtv == 1'b0, "R4 write ignored", 32'(r_dtv), 32'd0);

    // exact low threshold edge
    cfg_low_lat = 1'b1;
    @(negedge clk);
    chk(rd_req == 1'b0, "R2 3 of 4", 32'(rd_req), 32'd0);
    send_frame(8'h40, 1, 1'b1);
    chk(rd_req == 1'b1, "R2 4 of 4", 32'(rd_req), 32'd1);
    read_frame(8'h10, 3, 1'b0, "edge");
    read_frame(8'h40, 1, 1'b0, "edge single");
    access(1'b0, 2'd0, 2'b11);
    chk(r_dtv == 1'b0, "R3 empty read", 32'(r_dtv), 32'd0);

    // rejected frame
    send_frame(8'h55, 6, 1'b0);
    chk(rd_req == 1'b0, "R8 rejected not stored", 32'(rd_req), 32'd0);

    // sweep lengths and byte order
    for (int s = 0; s < 2; s++) begin
      cfg_swap = s[0];
      for (int len = 4; len < 12; len++) begin
        send_frame(len * 20 + s * 7, len, 1'b1);
        chk(rd_req == 1'b1, "R2 sweep request", 32'(rd_req), 32'd1);
        read_frame(len * 20 + s * 7, len, s[0], "sweep");
        @(negedge clk);
        chk(rd_req == 1'b0, "R2 sweep drained", 32'(rd_req), 32'd0);
      end
    end
    cfg_swap = 1'b0;

    // byte lane reads
    send_frame(8'hA0, 5, 1'b1);
    for (int i = 0; i < 5; i++) begin
      logic [1:0]  be;
      logic [15:0] ew;
      be = i[0] ? 2'b10 : 2'b01;
      ew = i[0] ? {8'(8'hA0 + i), 8'h00} : {8'h00, 8'(8'hA0 + i)};
      access(1'b0, 2'd0, be);
      chk(r_dtv && r_data == ew, "R6 byte lane", 32'(r_data), 32'(ew));
      chk(r_eof == (i == 4), "R5 byte eof", 32'(r_eof), 32'(i == 4));
    end

    // overflow
    cfg_low_lat = 1'b0;
    send_frame(8'h00, 20, 1'b1);
    chk(rd_req == 1'b1, "R2 hi threshold", 32'(rd_req), 32'd1);
    send_frame(8'h80, 20, 1'b1);
    chk(irq_cnt == 1, "R7 irq pulse", 32'(irq_cnt), 32'd1);
    send_frame(8'hC0, 3, 1'b1);
    send_frame(8'hD0, 3, 1'b0);
    access(1'b0, 2'd2, 2'b11);
    chk(r_dtv && r_data == 16'd2, "R9 missed count", 32'(r_data), 32'd2);
    access(1'b0, 2'd2, 2'b11);
    chk(r_data == 16'd0, "R9 clear on read", 32'(r_data), 32'd0);
    for (int k = 0; k < 300; k++) send_frame(k, 1, 1'b1);
    access(1'b0, 2'd2, 2'b11);
    chk(r_data == 16'd255, "R9 saturation", 32'(r_data), 32'd255);
    chk(rd_req == 1'b1, "R8 nothing added", 32'(rd_req), 32'd1);
    // kept frame: 20 bytes, request drops mid-drain
    for (int w = 0; w < 10; w++) begin
      logic [15:0] ew;
      if (w == 3) chk(rd_req == 1'b0, "R3 request dropped", 32'(rd_req), 32'd0);
      ew = {8'(2 * w + 1), 8'(2 * w)};
      access(1'b0, 2'd0, 2'b11);
      chk(r_dtv && r_data == ew, "R7 kept frame", 32'(r_data), 32'(ew));
      chk(r_eof == (w == 9), "R5 kept eof", 32'(r_eof), 32'(w == 9));
    end
    access(1'b0, 2'd0, 2'b11);
    chk(r_dtv == 1'b0, "R7 partial frame removed", 32'(r_dtv), 32'd0);
    access(1'b0, 2'd1, 2'b11);
    chk(r_dtv && r_data == 16'd1 && r_eof, "R10 status overflow", 32'(r_data), 32'd1);
    access(1'b0, 2'd1, 2'b11);
    chk(r_data == 16'd0 && !r_eof, "R10 status cleared", 32'(r_data), 32'd0);
    send_frame(8'hE0, 16, 1'b1);
    chk(rd_req == 1'b1, "R10 reception reopened", 32'(rd_req), 32'd1);
    read_frame(8'hE0, 16, 1'b0, "R10 after flush");
    chk(irq_cnt == 1, "R7 single irq", 32'(irq_cnt), 32'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule